// File: doc/BRIEF.md
# Transceiver Analog Settings Controller

This block keeps the analog-control settings of several transceiver channels: a transmit output-swing code and a receive equalisation code for each channel. A host selects a channel by its logical index, chooses which half of the channel the access covers (transmit, receive or both), and issues a single-cycle write or read strobe. Everything runs on one reconfiguration clock.

Each accepted access holds a busy flag high for a fixed, parameterised number of cycles. This stands in for the time needed to shift settings into the channel. A write takes effect when busy falls. A read returns the stored codes on the setting outputs and marks them with a one-cycle valid pulse in the cycle busy falls. Malformed or badly timed strobes are dropped and set a sticky error flag.

Top module: `pma_cfg_ctrl`

## Requirements
- R1: After reset, busy, rd_valid and err are low, both setting outputs are zero, and every stored code of every channel is zero.
- R2: A strobe is accepted when exactly one of wr_stb or rd_stb is high, busy is low and side_sel is not 2'b00. Busy is then high from the next cycle for exactly LATENCY cycles (8 by default). The channel index is ADDR_W = clog2(NUM_CH) bits wide, which is 2 bits for four channels.
- R3: A write with side_sel = 2'b10 replaces only the transmit swing code (TX_W = 3 bits) of the addressed channel. Its receive code and all other channels are left unchanged.
- R4: A write with side_sel = 2'b01 replaces only the receive code of the addressed channel. A write with side_sel = 2'b11 replaces both codes.
- R5: A read drives tx_out and rx_out with the addressed channel's stored codes and pulses rd_valid for one cycle, in the first cycle busy is low again. A half not selected by side_sel (bit 1 = transmit, bit 0 = receive) reads as zero.
- R6: A write never produces rd_valid and does not change tx_out or rx_out.
- R7: A strobe seen while busy is high is ignored: the running access keeps its length and data, and no stored code changes. It also sets err.
- R8: A strobe with side_sel = 2'b00 starts no access, leaves busy low, changes no stored code and sets err.
- R9: wr_stb and rd_stb high in the same cycle start no access, change no stored code and set err.
- R10: err stays high once set, through later legal accesses, until reset.
- R11: A strobe in the cycle busy has just fallen, which is also the cycle of the rd_valid pulse, is accepted.
- R12: tx_out and rx_out hold their values until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_addr | input | ADDR_W | Logical channel index |
| side_sel | input | 2 | Half selector: 10 transmit, 01 receive, 11 both |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| tx_swing_in | input | TX_W | Transmit swing code to write |
| rx_eq_in | input | RX_W | Receive equalisation code to write |
| tx_swing_out | output | TX_W | Transmit swing code read back |
| rx_eq_out | output | RX_W | Receive equalisation code read back |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle pulse: read data present |
| err | output | 1 | Sticky flag for dropped strobes |

## Verification
Two events can fall in the same cycle: the completion of a read, with busy falling and rd_valid pulsing, and the acceptance of a new strobe. The bench issues the next access at the very sample where it sees the valid pulse. It judges the case by two things: the returned data must be intact, and the new access must run its full busy window. The cycle before that boundary is probed as well. A strobe placed inside a running access must only raise err, and the later read-back shows that neither the running write nor the stored codes were disturbed.

// File: rtl/pma_cfg_pkg.sv
package pma_cfg_pkg;

  // Scope of an access within a channel; bit 1 = transmit half, bit 0 = receive half
  typedef enum logic [1:0] {
    SIDE_NONE = 2'b00,
    SIDE_RX   = 2'b01,
    SIDE_TX   = 2'b10,
    SIDE_BOTH = 2'b11
  } side_e;

  function automatic logic side_has_tx(input side_e s);
    return s[1];
  endfunction

  function automatic logic side_has_rx(input side_e s);
    return s[0];
  endfunction

endpackage

// File: rtl/pma_cfg_regfile.sv
module pma_cfg_regfile #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int TX_W   = 3,
  parameter int RX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              we_tx,
  input  logic              we_rx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TX_W-1:0]   tx_wdata,
  input  logic [RX_W-1:0]   rx_wdata,
  output logic [TX_W-1:0]   tx_rdata,
  output logic [RX_W-1:0]   rx_rdata
);

  logic [TX_W-1:0] tx_mem [NUM_CH];
  logic [RX_W-1:0] rx_mem [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    logic tx_en;
    logic rx_en;

    always_comb begin
      hit   = we && (addr == ADDR_W'(g));
      tx_en = hit && we_tx;
      rx_en = hit && we_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_mem[g] <= '0;
      end else if (tx_en) begin
        tx_mem[g] <= tx_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_mem[g] <= '0;
      end else if (rx_en) begin
        rx_mem[g] <= rx_wdata;
      end
    end
  end

  always_comb begin
    tx_rdata = tx_mem[addr];
    rx_rdata = rx_mem[addr];
  end

endmodule

// File: rtl/pma_cfg_seq.sv
module pma_cfg_seq
  import pma_cfg_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_stb,
  input  logic  rd_stb,
  input  side_e side,
  output logic  accept,
  output logic  finish,
  output logic  op_rd,
  output logic  busy,
  output logic  rd_valid,
  output logic  err
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             op_rd_q, op_rd_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             any_stb;
  logic             illegal;

  always_comb begin
    any_stb = wr_stb || rd_stb;
    accept  = (wr_stb ^ rd_stb) && !busy_q && (side != SIDE_NONE);
    illegal = any_stb && !accept;
    finish  = busy_q && (cnt_q == '0);

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    op_rd_d = op_rd_q;
    if (accept) begin
      busy_d  = 1'b1;
      cnt_d   = CNT_W'(LATENCY - 1);
      op_rd_d = rd_stb;
    end else if (finish) begin
      busy_d  = 1'b0;
    end else if (busy_q) begin
      cnt_d   = cnt_q - 1'b1;
    end

    valid_d = finish && op_rd_q;
    err_d   = err_q || illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      op_rd_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      op_rd_q <= op_rd_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    op_rd    = op_rd_q;
    busy     = busy_q;
    rd_valid = valid_q;
    err      = err_q;
  end

endmodule

// File: rtl/pma_cfg_ctrl.sv
module pma_cfg_ctrl
  import pma_cfg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int TX_W    = 3,
  parameter int RX_W    = 3,
  parameter int LATENCY = 8,
  parameter int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic [1:0]        side_sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [TX_W-1:0]   tx_swing_in,
  input  logic [RX_W-1:0]   rx_eq_in,
  output logic [TX_W-1:0]   tx_swing_out,
  output logic [RX_W-1:0]   rx_eq_out,
  output logic              busy,
  output logic              rd_valid,
  output logic              err
);

  side_e side_in;
  logic  accept, finish, op_rd;

  // captured access
  logic [ADDR_W-1:0] addr_q, addr_d;
  side_e             side_q, side_d;
  logic [TX_W-1:0]   txd_q, txd_d;
  logic [RX_W-1:0]   rxd_q, rxd_d;

  // read-back registers
  logic [TX_W-1:0]   txo_q, txo_d;
  logic [RX_W-1:0]   rxo_q, rxo_d;

  logic [TX_W-1:0]   tx_rdata;
  logic [RX_W-1:0]   rx_rdata;
  logic              mem_we, load_out;

  always_comb side_in = side_e'(side_sel);

  pma_cfg_seq #(.LATENCY(LATENCY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .side     (side_in),
    .accept   (accept),
    .finish   (finish),
    .op_rd    (op_rd),
    .busy     (busy),
    .rd_valid (rd_valid),
    .err      (err)
  );

  always_comb begin
    mem_we   = finish && !op_rd;
    load_out = finish && op_rd;

    addr_d = addr_q;
    side_d = side_q;
    txd_d  = txd_q;
    rxd_d  = rxd_q;
    if (accept) begin
      addr_d = chan_addr;
      side_d = side_in;
      txd_d  = tx_swing_in;
      rxd_d  = rx_eq_in;
    end

    txo_d = txo_q;
    rxo_d = rxo_q;
    if (load_out) begin
      txo_d = side_has_tx(side_q) ? tx_rdata : '0;
      rxo_d = side_has_rx(side_q) ? rx_rdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      side_q <= SIDE_NONE;
      txd_q  <= '0;
      rxd_q  <= '0;
      txo_q  <= '0;
      rxo_q  <= '0;
    end else begin
      addr_q <= addr_d;
      side_q <= side_d;
      txd_q  <= txd_d;
      rxd_q  <= rxd_d;
      txo_q  <= txo_d;
      rxo_q  <= rxo_d;
    end
  end

  pma_cfg_regfile #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .TX_W   (TX_W),
    .RX_W   (RX_W)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .we_tx    (side_has_tx(side_q)),
    .we_rx    (side_has_rx(side_q)),
    .addr     (addr_q),
    .tx_wdata (txd_q),
    .rx_wdata (rxd_q),
    .tx_rdata (tx_rdata),
    .rx_rdata (rx_rdata)
  );

  always_comb begin
    tx_swing_out = txo_q;
    rx_eq_out    = rxo_q;
  end

endmodule

// File: rtl/pma_cfg_chk.sv
module pma_cfg_chk #(
  parameter int TX_W    = 3,
  parameter int RX_W    = 3,
  parameter int LATENCY = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      side_sel,
  input logic            wr_stb,
  input logic            rd_stb,
  input logic [TX_W-1:0] tx_swing_out,
  input logic [RX_W-1:0] rx_eq_out,
  input logic            busy,
  input logic            rd_valid,
  input logic            err
);

  // length of the current busy window, counted in the checker
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= '0;
  end

  // R2, R11: a legal strobe with busy low starts an access
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (wr_stb ^ rd_stb) && side_sel != 2'b00) |=> busy);

  // R2: busy window is exactly LATENCY cycles
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == LATENCY));

  // R2: busy never rises without a strobe
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_stb || rd_stb));

  // R5: data valid only in the cycle busy falls
  assert_valid_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $fell(busy));

  // R5: data valid lasts one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R12, R6: outputs only move with a valid pulse
  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> ($stable(tx_swing_out) && $stable(rx_eq_out)));

  // R7: strobe during busy flags an error
  assert_busy_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (wr_stb || rd_stb)) |=> err);

  // R8: empty side selector starts nothing
  assert_no_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (wr_stb || rd_stb) && side_sel == 2'b00) |=> (!busy && err));

  // R9: both strobes together start nothing
  assert_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_stb && rd_stb) |=> (!busy && err));

  // R10: err is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind pma_cfg_ctrl pma_cfg_chk #(
  .TX_W    (TX_W),
  .RX_W    (RX_W),
  .LATENCY (LATENCY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .side_sel     (side_sel),
  .wr_stb       (wr_stb),
  .rd_stb       (rd_stb),
  .tx_swing_out (tx_swing_out),
  .rx_eq_out    (rx_eq_out),
  .busy         (busy),
  .rd_valid     (rd_valid),
  .err          (err)
);

// File: tb/sim_pma_cfg_ctrl.sv
module sim_pma_cfg_ctrl;

  localparam int LAT = 8;

  logic       clk;
  logic       rst_n;
  logic [1:0] chan_addr;
  logic [1:0] side_sel;
  logic       wr_stb, rd_stb;
  logic [2:0] tx_swing_in, rx_eq_in;
  logic [2:0] tx_swing_out, rx_eq_out;
  logic       busy, rd_valid, err;

  pma_cfg_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_addr    (chan_addr),
    .side_sel     (side_sel),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .tx_swing_in  (tx_swing_in),
    .rx_eq_in     (rx_eq_in),
    .tx_swing_out (tx_swing_out),
    .rx_eq_out    (rx_eq_out),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .err          (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {is_read, chan, side, tx_in, rx_in, exp_tx, exp_rx}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'b11, 3'd5, 3'd3, 3'd0, 3'd0},
    {1'b0, 2'd1, 2'b10, 3'd7, 3'd6, 3'd0, 3'd0},
    {1'b0, 2'd2, 2'b01, 3'd2, 3'd4, 3'd0, 3'd0},
    {1'b0, 2'd3, 2'b11, 3'd1, 3'd7, 3'd0, 3'd0},
    {1'b0, 2'd0, 2'b10, 3'd6, 3'd1, 3'd0, 3'd0},
    {1'b1, 2'd0, 2'b11, 3'd0, 3'd0, 3'd6, 3'd3},
    {1'b1, 2'd1, 2'b11, 3'd0, 3'd0, 3'd7, 3'd0},
    {1'b1, 2'd2, 2'b11, 3'd0, 3'd0, 3'd0, 3'd4},
    {1'b1, 2'd3, 2'b10, 3'd0, 3'd0, 3'd1, 3'd0},
    {1'b1, 2'd0, 2'b01, 3'd0, 3'd0, 3'd0, 3'd3},
    {1'b0, 2'd2, 2'b01, 3'd7, 3'd5, 3'd0, 3'd0},
    {1'b1, 2'd2, 2'b11, 3'd0, 3'd0, 3'd0, 3'd5}
  };

  task automatic do_reset();
    rst_n = 1'b0;
    wr_stb = 1'b0; rd_stb = 1'b0;
    chan_addr = '0; side_sel = 2'b00; tx_swing_in = '0; rx_eq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive one strobe, count busy cycles, return at the first sample with busy low.
  task automatic access(input bit imm, input bit w, input bit r, input logic [1:0] ch,
                        input logic [1:0] sd, input logic [2:0] t, input logic [2:0] x,
                        output int nbusy, output logic vld);
    if (!imm) @(negedge clk);
    wr_stb = w; rd_stb = r; chan_addr = ch; side_sel = sd;
    tx_swing_in = t; rx_eq_in = x;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    nbusy = 0;
    while (busy && nbusy < 100) begin
      nbusy++;
      @(negedge clk);
    end
    vld = rd_valid;
  endtask

  initial begin
    int   nb;
    logic v;
    logic [2:0] last_tx, last_rx;

    do_reset();
    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check(err == 1'b0, "R1 err", err, 0);
    check(tx_swing_out == 3'd0 && rx_eq_out == 3'd0, "R1 outputs", {tx_swing_out, rx_eq_out}, 0);
    access(0, 0, 1, 2'd3, 2'b11, 3'd0, 3'd0, nb, v);
    check(tx_swing_out == 3'd0 && rx_eq_out == 3'd0, "R1 stored codes", {tx_swing_out, rx_eq_out}, 0);

    last_tx = tx_swing_out; last_rx = rx_eq_out;
    for (int i = 0; i < NV; i++) begin
      logic [16:0] e;
      e = VEC[i];
      access(0, !e[16], e[16], e[15:14], e[13:12], e[11:9], e[8:6], nb, v);
      check(nb == LAT, "R2 busy length", nb, LAT);
      if (e[16]) begin
        // R3 R4 R5: read back what earlier writes stored, unselected half zero
        check(v == 1'b1, "R5 rd_valid", v, 1);
        check(tx_swing_out == e[5:3], "R3/R5 tx read", tx_swing_out, e[5:3]);
        check(rx_eq_out == e[2:0], "R4/R5 rx read", rx_eq_out, e[2:0]);
        last_tx = tx_swing_out; last_rx = rx_eq_out;
      end else begin
        // R6 R12: writes give no valid and leave outputs alone
        check(v == 1'b0, "R6 no valid on write", v, 0);
        check(tx_swing_out == last_tx && rx_eq_out == last_rx, "R12 outputs held",
              {tx_swing_out, rx_eq_out}, {last_tx, last_rx});
      end
      @(negedge clk);
      check(rd_valid == 1'b0, "R5 valid one cycle", rd_valid, 0);
    end
    check(err == 1'b0, "R2 no err on legal traffic", err, 0);

    // R11: strobe in the valid cycle is accepted
    access(0, 0, 1, 2'd1, 2'b10, 3'd0, 3'd0, nb, v);
    check(v == 1'b1 && tx_swing_out == 3'd7, "R11 first read", tx_swing_out, 7);
    access(1, 0, 1, 2'd3, 2'b01, 3'd0, 3'd0, nb, v);
    check(nb == LAT, "R11 back-to-back accepted", nb, LAT);
    check(rx_eq_out == 3'd7 && tx_swing_out == 3'd0, "R11 second read", {tx_swing_out, rx_eq_out}, 7);
    check(err == 1'b0, "R11 no err", err, 0);

    // R7: strobe while busy is ignored and flags err
    @(negedge clk);
    wr_stb = 1'b1; chan_addr = 2'd1; side_sel = 2'b11; tx_swing_in = 3'd3; rx_eq_in = 3'd3;
    @(negedge clk);
    wr_stb = 1'b0;
    nb = 0;
    while (busy && nb < 100) begin
      nb++;
      if (nb == 2) begin
        wr_stb = 1'b1; chan_addr = 2'd0; side_sel = 2'b11; tx_swing_in = 3'd2; rx_eq_in = 3'd2;
      end else if (nb == 3) begin
        wr_stb = 1'b0;
      end
      if (nb == LAT) begin
        // last busy cycle: a strobe here must also be dropped
        rd_stb = 1'b1; chan_addr = 2'd2; side_sel = 2'b11;
      end
      @(negedge clk);
      rd_stb = 1'b0;
    end
    check(nb == LAT, "R7 running access length kept", nb, LAT);
    check(rd_valid == 1'b0, "R7 no valid from dropped read", rd_valid, 0);
    check(err == 1'b1, "R7 err set", err, 1);
    access(0, 0, 1, 2'd1, 2'b11, 3'd0, 3'd0, nb, v);
    check(tx_swing_out == 3'd3 && rx_eq_out == 3'd3, "R7 running write intact",
          {tx_swing_out, rx_eq_out}, {3'd3, 3'd3});
    access(0, 0, 1, 2'd0, 2'b11, 3'd0, 3'd0, nb, v);
    check(tx_swing_out == 3'd6 && rx_eq_out == 3'd3, "R7 dropped write no effect",
          {tx_swing_out, rx_eq_out}, {3'd6, 3'd3});

    // R8: empty side selector
    do_reset();
    access(0, 1, 0, 2'd0, 2'b00, 3'd7, 3'd7, nb, v);
    check(nb == 0, "R8 no access", nb, 0);
    check(err == 1'b1, "R8 err set", err, 1);
    access(0, 0, 1, 2'd0, 2'b11, 3'd0, 3'd0, nb, v);
    check(tx_swing_out == 3'd0 && rx_eq_out == 3'd0, "R8 nothing stored",
          {tx_swing_out, rx_eq_out}, 0);

    // R9: both strobes at once
    do_reset();
    access(0, 1, 1, 2'd0, 2'b11, 3'd7, 3'd7, nb, v);
    check(nb == 0, "R9 no access", nb, 0);
    check(err == 1'b1, "R9 err set", err, 1);
    access(0, 0, 1, 2'd0, 2'b11, 3'd0, 3'd0, nb, v);
    check(tx_swing_out == 3'd0 && rx_eq_out == 3'd0, "R9 nothing stored",
          {tx_swing_out, rx_eq_out}, 0);
    // R10: sticky through a legal access, cleared by reset
    check(err == 1'b1, "R10 err sticky", err, 1);
    do_reset();
    check(err == 1'b0, "R10 err cleared by reset", err, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule